// File: doc/BRIEF.md
# Splittable Performance Counter Bank

This block holds a small set of physical event counters behind a single-port register interface. Each physical counter runs either as one full-width counter or as two independent half-width counters, which doubles the number of logical counters software can address. Counting is gated by one global enable bit in a control word. That word also carries one split-mode bit per physical counter.

Software never writes a live counter directly. A counter write lands in a per-counter holding latch, and a pending flag is set. The latch is copied into the live counter when the control word is written with the enable bit set. This covers both turning the monitor on and rewriting the control word while it is already on. Until that commit, a read of the counter returns the staged value.

Wrap-around of any counter or half-counter records a sticky overflow bit. A status read returns these bits and clears them in the same access. Writing the status address loads an interrupt mask, and an interrupt line is driven from the masked pending bits.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, all live counters, holding latches, the control word, the pending overflow bits and the interrupt mask are zero, and `irq` is low.
- R2: A read issued with `rdEn` returns its data on `rdData` one cycle later with `rdValid` high. Address map with defaults: 0–7 are logical counters, 8 is the control word, 9 is the status/mask register, and any other address reads as zero.
- R3: In full-width mode, physical counter p increments by one on each cycle in which the enable bit is set and `evt[p]` is high. While the enable bit is clear, it holds its value.
- R4: With split bit p set, logical counter p is the upper half of physical counter p and counts `evt[p]`. Logical counter p+4 is the lower half and counts `evt[p+4]`. The halves count independently, and a wrap of one half never carries into the other.
- R5: When physical counter p is in full-width mode, logical counter p+4 reads as zero, and a write to it changes nothing.
- R6: A counter write only updates the holding latch and marks it pending. While pending, a read of that counter returns the latched value, even if the live counter keeps counting.
- R7: A control-word write with bit 0 (enable) set copies every pending latch into its live counter and clears all pending flags. This applies both when enable rises and when the word is rewritten while already enabled.
- R8: In split mode, a write to one half keeps the other half's current visible value, which is the latched value if pending and otherwise the live one.
- R9: A wrap from all-ones to zero sets a sticky status bit. Bit p marks full-width counter p or the upper half p, and bit p+4 marks lower half p.
- R10: A status read returns the pending overflow bits and clears them in that access. An overflow arriving in the same cycle is kept.
- R11: A status write loads the interrupt mask from `wrData[7:0]`. `irq` is high exactly while some pending bit has its mask bit set. Writing zero masks every source.
- R12: The control word reads back with bit 0 as enable and bits 4:1 as the split bits for physical counters 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wrData | input | 32 | Write data |
| evt | input | 8 | Per-logical-counter event inputs |
| rdData | output | 32 | Read data, valid one cycle after `rdEn` |
| rdValid | output | 1 | Read data valid |
| irq | output | 1 | Masked overflow interrupt |

## Verification
The bench keeps counting while a write is staged. A design that wrote the live counter directly, or that read the live value instead of the latch, would return the wrong number before the rewrite commit. Split-mode writes are issued back to back on both halves of one counter. A merge that used the stale live value would lose the first half. Each half is driven to its wrap point separately: a carry leaking between halves would disturb the neighbour, and a wrong status bit position would raise the wrong bit or fire `irq` under a zero mask. Writes to an upper logical index in full-width mode are followed by reads of both indices, so a design that aliased them onto the full counter would show a nonzero value.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  typedef enum logic [1:0] {
    PART_NONE,
    PART_FULL,
    PART_UPPER,
    PART_LOWER
  } latchPart_e;

  // Strobes from control decode to the counter datapath
  typedef struct packed {
    logic       latchWr;
    latchPart_e part;
    logic       commit;
  } dpStrobe_t;

endpackage

// File: rtl/pcb_ctrl.sv
module pcb_ctrl
  import pcb_pkg::*;
#(
  parameter int NUM_PHYS = 4,
  parameter int CTR_W    = 32,
  localparam int NLOG    = 2 * NUM_PHYS,
  localparam int IDX_W   = $clog2(NLOG),
  localparam int ADDR_W  = IDX_W + 1,
  localparam int PHYS_W  = IDX_W - 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NLOG-1:0]     regWrData,
  input  logic [NLOG-1:0]     ovf,
  input  logic [CTR_W-1:0]    dpRdVal,
  output dpStrobe_t           strobe,
  output logic                cfgEnable,
  output logic [NUM_PHYS-1:0] cfgSplit,
  output logic [CTR_W-1:0]    rdData,
  output logic                rdValid,
  output logic                irq
);

  logic isCtr, isCtrl, isStat, upperSel, statRd;
  logic [PHYS_W-1:0] physSel;
  latchPart_e part;
  logic [NLOG-1:0] statusQ, maskQ;
  logic [CTR_W-1:0] ctrlWord, rdNext;

  assign isCtr    = ~addr[IDX_W];
  assign isCtrl   = addr[IDX_W] && (addr[IDX_W-1:0] == IDX_W'(0));
  assign isStat   = addr[IDX_W] && (addr[IDX_W-1:0] == IDX_W'(1));
  assign physSel  = addr[PHYS_W-1:0];
  assign upperSel = ~addr[IDX_W-1];
  assign statRd   = rdEn && isStat;

  always_comb begin
    if (cfgSplit[physSel]) part = upperSel ? PART_UPPER : PART_LOWER;
    else                   part = upperSel ? PART_FULL  : PART_NONE;
  end

  assign strobe.latchWr = wrEn && isCtr && (part != PART_NONE);
  assign strobe.part    = part;
  assign strobe.commit  = wrEn && isCtrl && regWrData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEnable <= 1'b0;
      cfgSplit  <= '0;
      maskQ     <= '0;
      statusQ   <= '0;
    end else begin
      if (wrEn && isCtrl) begin
        cfgEnable <= regWrData[0];
        cfgSplit  <= regWrData[NUM_PHYS:1];
      end
      if (wrEn && isStat) maskQ <= regWrData;
      statusQ <= (statRd ? '0 : statusQ) | ovf;
    end
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[0] = cfgEnable;
    ctrlWord[NUM_PHYS:1] = cfgSplit;
    if (isCtr)       rdNext = dpRdVal;
    else if (isCtrl) rdNext = ctrlWord;
    else if (isStat) rdNext = CTR_W'(statusQ);
    else             rdNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) rdData <= rdNext;
    end
  end

  assign irq = |(statusQ & maskQ);

  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  p_status_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    !statRd |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  p_status_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && ovf == '0) |=> (statusQ == '0));

  p_mask_zero_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isStat && regWrData == '0) |=> !irq);

endmodule

// File: rtl/pcb_datapath.sv
module pcb_datapath
  import pcb_pkg::*;
#(
  parameter int NUM_PHYS = 4,
  parameter int CTR_W    = 32,
  localparam int NLOG    = 2 * NUM_PHYS,
  localparam int IDX_W   = $clog2(NLOG),
  localparam int PHYS_W  = IDX_W - 1,
  localparam int HALF_W  = CTR_W / 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [IDX_W-1:0]    idx,
  input  logic [CTR_W-1:0]    wrData,
  input  logic                cfgEnable,
  input  logic [NUM_PHYS-1:0] cfgSplit,
  input  logic [NLOG-1:0]     evt,
  output logic [CTR_W-1:0]    rdVal,
  output logic [NLOG-1:0]     ovf
);

  logic [NUM_PHYS*CTR_W-1:0] curFlat, liveFlat;
  logic [NUM_PHYS-1:0] pendVec;
  logic [PHYS_W-1:0] physSel;

  assign physSel = idx[PHYS_W-1:0];

  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_ctr
    logic [CTR_W-1:0] liveQ, latchQ, cur;
    logic pendQ, hit, commitP, hiMax, loMax, evHi, evLo;

    assign cur     = pendQ ? latchQ : liveQ;
    assign hit     = strobe.latchWr && (physSel == PHYS_W'(p));
    assign commitP = strobe.commit && pendQ;
    assign hiMax   = &liveQ[CTR_W-1:HALF_W];
    assign loMax   = &liveQ[HALF_W-1:0];
    assign evHi    = evt[p];
    assign evLo    = evt[p+NUM_PHYS];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        latchQ <= '0;
        pendQ  <= 1'b0;
      end else if (hit) begin
        pendQ <= 1'b1;
        case (strobe.part)
          PART_FULL:  latchQ <= wrData;
          PART_UPPER: latchQ <= {wrData[HALF_W-1:0], cur[HALF_W-1:0]};
          PART_LOWER: latchQ <= {cur[CTR_W-1:HALF_W], wrData[HALF_W-1:0]};
          default:    latchQ <= latchQ;
        endcase
      end else if (strobe.commit) begin
        pendQ <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        liveQ <= '0;
      end else if (commitP) begin
        liveQ <= latchQ;
      end else if (cfgEnable) begin
        if (cfgSplit[p]) begin
          liveQ[CTR_W-1:HALF_W] <= liveQ[CTR_W-1:HALF_W] + HALF_W'(evHi);
          liveQ[HALF_W-1:0]     <= liveQ[HALF_W-1:0] + HALF_W'(evLo);
        end else begin
          liveQ <= liveQ + CTR_W'(evHi);
        end
      end
    end

    assign ovf[p] = cfgEnable && !commitP && evHi &&
                    (cfgSplit[p] ? hiMax : (hiMax && loMax));
    assign ovf[p+NUM_PHYS] = cfgEnable && !commitP && evLo && cfgSplit[p] && loMax;

    assign curFlat[p*CTR_W +: CTR_W]  = cur;
    assign liveFlat[p*CTR_W +: CTR_W] = liveQ;
    assign pendVec[p] = pendQ;
  end

  always_comb begin
    logic [CTR_W-1:0] v;
    v = curFlat[int'(physSel)*CTR_W +: CTR_W];
    if (cfgSplit[physSel])
      rdVal = idx[IDX_W-1] ? CTR_W'(v[HALF_W-1:0]) : CTR_W'(v[CTR_W-1:HALF_W]);
    else
      rdVal = idx[IDX_W-1] ? '0 : v;
  end

  p_frozen_when_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEnable && !strobe.commit) |=> $stable(liveFlat));

  p_latch_write_pends_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchWr |=> (pendVec != '0));

  p_commit_clears_pending_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> (pendVec == '0));

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pcb_pkg::*;
#(
  parameter int NUM_PHYS = 4,
  parameter int CTR_W    = 32,
  localparam int NLOG    = 2 * NUM_PHYS,
  localparam int IDX_W   = $clog2(NLOG),
  localparam int ADDR_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTR_W-1:0]  wrData,
  input  logic [NLOG-1:0]   evt,
  output logic [CTR_W-1:0]  rdData,
  output logic              rdValid,
  output logic              irq
);

  dpStrobe_t strobe;
  logic cfgEnable;
  logic [NUM_PHYS-1:0] cfgSplit;
  logic [CTR_W-1:0] dpRdVal;
  logic [NLOG-1:0] ovf;

  pcb_ctrl #(.NUM_PHYS(NUM_PHYS), .CTR_W(CTR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .regWrData(wrData[NLOG-1:0]), .ovf(ovf), .dpRdVal(dpRdVal),
    .strobe(strobe), .cfgEnable(cfgEnable), .cfgSplit(cfgSplit),
    .rdData(rdData), .rdValid(rdValid), .irq(irq)
  );

  pcb_datapath #(.NUM_PHYS(NUM_PHYS), .CTR_W(CTR_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .idx(addr[IDX_W-1:0]),
    .wrData(wrData), .cfgEnable(cfgEnable), .cfgSplit(cfgSplit),
    .evt(evt), .rdVal(dpRdVal), .ovf(ovf)
  );

endmodule

// File: tb/tb_perf_counter_bank.sv
module tb_perf_counter_bank;

  logic clk = 1'b0;
  logic rstN, wrEn, rdEn, rdValid, irq;
  logic [3:0]  addr;
  logic [31:0] wrData, rdData;
  logic [7:0]  evt;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [31:0] expQ[$];
  string tagQ[$];

  localparam logic [3:0] A_CTRL = 4'd8, A_STAT = 4'd9;

  always #2.5 clk = ~clk;

  perf_counter_bank dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .evt(evt), .rdData(rdData), .rdValid(rdValid), .irq(irq)
  );

  task automatic wrReg(input logic [3:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, input logic [31:0] exp, input string tag);
    rdEn = 1'b1; addr = a;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m, input int n);
    evt = m;
    repeat (n) @(negedge clk);
    evt = '0;
  endtask

  task automatic checkIrq(input logic exp, input string tag);
    vectors++;
    if (irq !== exp) begin
      miscompares++;
      $display("FAIL %s irq: actual=%0b expected=%0b", tag, irq, exp);
    end
  endtask

  // Monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rstN === 1'b1 && rdValid === 1'b1) begin
      logic [31:0] e;
      string t;
      vectors++;
      if (expQ.size() == 0) begin
        miscompares++;
        $display("FAIL R2 unexpected rdValid: actual=1 expected=0");
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (rdData !== e) begin
          miscompares++;
          $display("FAIL %s: actual=%08h expected=%08h", t, rdData, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; addr = '0; wrData = '0; evt = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkIrq(1'b0, "R1");
    rdReg(A_CTRL, 32'h0, "R1 control");
    rdReg(4'd0, 32'h0, "R1 counter0");
    rdReg(4'd5, 32'h0, "R1 counter5");
    rdReg(A_STAT, 32'h0, "R1 status");

    // R6 staged write while disabled, R7 commit on enable rise, R3 counting
    wrReg(4'd0, 32'h100);
    rdReg(4'd0, 32'h100, "R6 latched read");
    wrReg(A_CTRL, 32'h1);
    pulse(8'h01, 5);
    rdReg(4'd0, 32'h105, "R3 count 32-bit");
    rdReg(A_CTRL, 32'h1, "R12 control readback");

    // R6 staged write while enabled, counting continues underneath
    wrReg(4'd0, 32'h50);
    pulse(8'h01, 3);
    rdReg(4'd0, 32'h50, "R6 pending read while counting");
    wrReg(A_CTRL, 32'h1);
    rdReg(4'd0, 32'h50, "R7 rewrite commit");
    pulse(8'h01, 2);
    rdReg(4'd0, 32'h52, "R3 count after commit");

    // R3 hold while disabled
    wrReg(A_CTRL, 32'h0);
    pulse(8'h01, 4);
    rdReg(4'd0, 32'h52, "R3 hold when disabled");

    // R5 upper index in full-width mode
    wrReg(4'd5, 32'hABCD);
    rdReg(4'd5, 32'h0, "R5 logical5 reads zero");
    rdReg(4'd1, 32'h0, "R5 write ignored counter1");
    wrReg(A_CTRL, 32'h1);
    rdReg(4'd1, 32'h0, "R5 nothing committed");

    // R8 split half writes, R4 independent halves
    wrReg(A_CTRL, 32'h5);
    wrReg(4'd1, 32'h1234);
    wrReg(4'd5, 32'h00FF);
    rdReg(4'd1, 32'h1234, "R8 upper half kept");
    rdReg(4'd5, 32'h00FF, "R8 lower half");
    wrReg(A_CTRL, 32'h5);
    pulse(8'h22, 2);
    pulse(8'h02, 1);
    rdReg(4'd1, 32'h1237, "R4 upper count");
    rdReg(4'd5, 32'h0101, "R4 lower count");
    rdReg(A_CTRL, 32'h5, "R12 split bit readback");

    // R9 lower-half wrap, R11 masked irq, R10 read-clear, R4 no carry
    wrReg(4'd5, 32'hFFFE);
    wrReg(A_CTRL, 32'h5);
    wrReg(A_STAT, 32'h20);
    pulse(8'h20, 2);
    checkIrq(1'b1, "R11 irq on masked overflow");
    rdReg(4'd1, 32'h1237, "R4 no carry into upper");
    rdReg(4'd5, 32'h0, "R9 lower wrapped");
    rdReg(A_STAT, 32'h20, "R9 status bit5");
    rdReg(A_STAT, 32'h0, "R10 status cleared");
    checkIrq(1'b0, "R10 irq after clear");

    // R9 full-width wrap with zero mask
    wrReg(A_STAT, 32'h0);
    wrReg(4'd0, 32'hFFFF_FFFF);
    wrReg(A_CTRL, 32'h5);
    pulse(8'h01, 1);
    checkIrq(1'b0, "R11 zero mask quiet");
    rdReg(4'd0, 32'h0, "R9 full wrap value");
    rdReg(A_STAT, 32'h01, "R9 status bit0");

    // R9 upper-half wrap
    wrReg(4'd1, 32'hFFFF);
    wrReg(A_CTRL, 32'h5);
    wrReg(A_STAT, 32'h02);
    pulse(8'h02, 1);
    checkIrq(1'b1, "R11 irq upper half");
    rdReg(A_STAT, 32'h02, "R9 status bit1");
    checkIrq(1'b0, "R10 irq cleared");
    rdReg(4'd1, 32'h0, "R4 upper wrapped");
    rdReg(4'd5, 32'h0, "R4 lower untouched");

    // R2 unmapped address
    rdReg(4'd10, 32'h0, "R2 unmapped read");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      miscompares++;
      $display("FAIL R2 missing reads: actual=%0d expected=0", expQ.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule